// File: doc/BRIEF.md
# Token-Ordered Completion Buffer

This block restores issue order for work that finishes out of order. A requester first takes a token, which is the index of a slot that the buffer reserves for it. Later, possibly after other requests have finished, the finished value comes back on the put port together with its token. The consumer side always sees the oldest reserved slot, and it can remove that slot only once its value has arrived. Tokens are handed out in order and then filled in any order, but results leave strictly in the order their tokens were issued.

Internally the block is a ring of slots, each with a valid flag and a data word, plus an insert pointer, a remove pointer and an occupancy count. All three ports may act in the same clock cycle. The effective order inside a cycle is issue, then fill, then release. A recirculating lookup pipeline can therefore start a new request in the cycle that an old one leaves, without a dead cycle. A value put into the oldest slot can leave in that same cycle. When the buffer is empty, a token can be issued, filled and released all in one cycle.

Top module: `inorder_cbuf`

## Requirements
- R1: After reset the buffer is empty: `tokRdy` is 1, `resVld` is 0 and the first token offered on `tokId` is 0.
- R2: Tokens are issued in sequence 0, 1, …, CAP-1 and then wrap to 0. `tokId` shows the token the next issue will return, and an issue happens in a cycle where `tokTake` and `tokRdy` are both 1.
- R3: `tokRdy` is 0 while CAP tokens are outstanding. A `tokTake` in such a cycle is ignored: no slot is reserved and `tokId` is unchanged in the next cycle.
- R4: A put (`putEn`=1) stores `putData` as the valid value of the slot named by `putTok`. Puts may arrive in any order relative to the order in which tokens were issued.
- R5: `resVld` is 1 only when at least one token is outstanding and the slot of the oldest outstanding token holds a valid value. `resData` then carries that value, so results leave in token-issue order.
- R6: A release (`resVld`=1 and `resTake`=1) frees the oldest slot and moves on to the next token. While `resTake` is 0, the head result stays offered unchanged.
- R7: A put to the oldest outstanding slot raises `resVld` and presents `putData` on `resData` in the same cycle, and it may be released in that cycle.
- R8: An issue and a release in the same cycle leave the occupancy unchanged. `tokRdy` depends only on the occupancy at the start of the cycle, so on a full buffer a release frees issue capacity from the next cycle on.
- R9: On an empty buffer, an issue, a put carrying the token being issued and a release may all happen in one cycle. The value is delivered and the buffer is empty again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| tokTake | input | 1 | Requester takes the offered token this cycle |
| tokRdy | output | 1 | A free slot exists, so a token can be taken |
| tokId | output | TW | Token that the next issue returns |
| putEn | input | 1 | Put strobe: a finished value arrives |
| putTok | input | TW | Token that the finished value belongs to |
| putData | input | DW | Finished value |
| resTake | input | 1 | Consumer takes the head result this cycle |
| resVld | output | 1 | Head result is available |
| resData | output | DW | Value of the oldest outstanding token |

## Verification
The embedded assertions watch properties that hold in every cycle: the count stays within capacity, the insert pointer stays in range, a refused take leaves the pointer still, a simultaneous issue and release keep the count, a release decrements it, a put marks its slot valid and a release clears it. Ordering across many tokens, the same-cycle bypass of a put into the head, the one-cycle delay before a full buffer reissues, and the empty-buffer case with all three ports active depend on whole sequences. Only the bench scenarios show these, with a queue model checked every cycle, including a long stretch of random traffic with out-of-order puts.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Write strobes sent from the control to the slot store.
  typedef struct packed {
    logic issueStb;   // clear the slot at the insert position
    logic retireStb;  // clear the slot at the remove position
  } cbufStrobe_t;

endpackage

// File: rtl/cbuf_dpath.sv
module cbuf_dpath
  import cbuf_pkg::*;
#(
  parameter int CAP = 16,
  parameter int TW  = 4,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  cbufStrobe_t   strb,
  input  logic [TW-1:0] insSlot,
  input  logic [TW-1:0] remSlot,
  input  logic          putEn,
  input  logic [TW-1:0] putTok,
  input  logic [DW-1:0] putData,
  output logic          headHit,
  output logic [DW-1:0] headData
);

  logic [CAP-1:0] slotVld;
  logic [DW-1:0]  slotDat [CAP];
  logic           putHead;

  // Each slot applies issue, then put, then retire: the last write wins.
  for (genvar i = 0; i < CAP; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotVld[i] <= 1'b0;
      end else begin
        if (strb.issueStb && insSlot == TW'(i))  slotVld[i] <= 1'b0;
        if (putEn && putTok == TW'(i))           slotVld[i] <= 1'b1;
        if (strb.retireStb && remSlot == TW'(i)) slotVld[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (putEn && putTok == TW'(i)) slotDat[i] <= putData;
    end
  end

  // A put to the head slot is visible to the reader in the same cycle.
  always_comb begin
    putHead  = putEn && (putTok == remSlot);
    headHit  = putHead || slotVld[remSlot];
    headData = putHead ? putData : slotDat[remSlot];
  end

  // R4
  put_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (putEn && !(strb.retireStb && putTok == remSlot)) |=> slotVld[$past(putTok)]);

  // R6
  retire_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.retireStb |=> !slotVld[$past(remSlot)]);

endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
  import cbuf_pkg::*;
#(
  parameter int CAP = 16,
  parameter int TW  = 4,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tokTake,
  input  logic          resTake,
  input  logic          headHit,
  output logic          tokRdy,
  output logic [TW-1:0] tokId,
  output logic          resVld,
  output cbufStrobe_t   strb,
  output logic [TW-1:0] insSlot,
  output logic [TW-1:0] remSlot
);

  localparam logic [PW-1:0] LAST = PW'(CAP - 1);
  localparam logic [PW-1:0] FULL = PW'(CAP);

  logic [PW-1:0] insQ, remQ, cntQ;
  logic          issueFire, retireFire, occupied;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    occupied   = (cntQ != '0);
    tokRdy     = (cntQ != FULL);
    issueFire  = tokTake && tokRdy;
    // Issue precedes release: on an empty buffer the token issued this
    // cycle is already the head.
    resVld     = headHit && (occupied || issueFire);
    retireFire = resVld && resTake;
    tokId      = insQ[TW-1:0];
    insSlot    = insQ[TW-1:0];
    remSlot    = remQ[TW-1:0];
    strb.issueStb  = issueFire;
    strb.retireStb = retireFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insQ <= '0;
      remQ <= '0;
      cntQ <= '0;
    end else begin
      if (issueFire)  insQ <= bump(insQ);
      if (retireFire) remQ <= bump(remQ);
      unique case ({issueFire, retireFire})
        2'b10:   cntQ <= cntQ + PW'(1);
        2'b01:   cntQ <= cntQ - PW'(1);
        default: cntQ <= cntQ;
      endcase
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FULL);

  // R2
  ins_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    insQ <= LAST);

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == FULL && tokTake) |=> $stable(insQ));

  // R8
  swap_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueFire && retireFire) |=> $stable(cntQ));

  // R6
  retire_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retireFire && !issueFire) |=> cntQ == $past(cntQ) - PW'(1));

endmodule

// File: rtl/inorder_cbuf.sv
module inorder_cbuf
  import cbuf_pkg::*;
#(
  parameter int CAP = 16,
  parameter int DW  = 32,
  localparam int TW = (CAP > 1) ? $clog2(CAP) : 1,
  localparam int PW = TW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tokTake,
  output logic          tokRdy,
  output logic [TW-1:0] tokId,
  input  logic          putEn,
  input  logic [TW-1:0] putTok,
  input  logic [DW-1:0] putData,
  input  logic          resTake,
  output logic          resVld,
  output logic [DW-1:0] resData
);

  cbufStrobe_t   strb;
  logic [TW-1:0] insSlot, remSlot;
  logic          headHit;

  cbuf_ctrl #(.CAP(CAP), .TW(TW), .PW(PW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tokTake (tokTake),
    .resTake (resTake),
    .headHit (headHit),
    .tokRdy  (tokRdy),
    .tokId   (tokId),
    .resVld  (resVld),
    .strb    (strb),
    .insSlot (insSlot),
    .remSlot (remSlot)
  );

  cbuf_dpath #(.CAP(CAP), .TW(TW), .DW(DW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .insSlot  (insSlot),
    .remSlot  (remSlot),
    .putEn    (putEn),
    .putTok   (putTok),
    .putData  (putData),
    .headHit  (headHit),
    .headData (resData)
  );

endmodule

// File: tb/sim_inorder_cbuf.sv
module sim_inorder_cbuf;
  localparam int CAP = 16;
  localparam int TW  = 4;
  localparam int DW  = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, tokTake, tokRdy, putEn, resTake, resVld;
  logic [TW-1:0] tokId, putTok;
  logic [DW-1:0] putData, resData;

  inorder_cbuf #(.CAP(CAP), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .tokTake(tokTake), .tokRdy(tokRdy), .tokId(tokId),
    .putEn(putEn), .putTok(putTok), .putData(putData),
    .resTake(resTake), .resVld(resVld), .resData(resData)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // Reference model: queue of outstanding tokens in issue order.
  int          q[$];
  bit          val[CAP];
  logic [DW-1:0] mem[CAP];
  int          ins = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit tt, bit pe, int ptok, logic [DW-1:0] pd, bit rt, string tag);
    bit expRdy, iss, expVld;
    int expTok;
    @(negedge clk);
    tokTake = tt; putEn = pe; putTok = TW'(ptok); putData = pd; resTake = rt;
    #1;
    expRdy = (q.size() < CAP);
    expTok = ins;
    iss    = tt && expRdy;
    if (iss) begin val[ins] = 0; q.push_back(ins); ins = (ins + 1) % CAP; end
    if (pe)  begin val[ptok] = 1; mem[ptok] = pd; end
    expVld = (q.size() > 0) && val[q[0]];
    chk(tag, "tokRdy", 64'(tokRdy), 64'(expRdy));
    if (expRdy) chk(tag, "tokId", 64'(tokId), 64'(expTok));
    chk(tag, "resVld", 64'(resVld), 64'(expVld));
    if (expVld) begin
      chk(tag, "resData", 64'(resData), 64'(mem[q[0]]));
      if (rt) begin val[q[0]] = 0; void'(q.pop_front()); end
    end
  endtask

  // Oldest outstanding token still waiting for its value, or -1.
  function automatic int firstUnfilled();
    foreach (q[k]) if (!val[q[k]]) return q[k];
    return -1;
  endfunction

  task automatic drain(string tag);
    while (q.size() > 0) begin
      int t = firstUnfilled();
      if (t >= 0) step(0, 1, t, $urandom, 1, tag);
      else        step(0, 0, 0, '0, 1, tag);
    end
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; tokTake = 0; putEn = 0; putTok = '0; putData = '0; resTake = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    step(0, 0, 0, '0, 0, "R1");

    // R2: four tokens in sequence
    for (int i = 0; i < 4; i++) step(1, 0, 0, '0, 0, "R2");
    // R4/R5: later tokens filled first, nothing may leave
    for (int i = 3; i >= 1; i--) step(0, 1, i, 32'hA0 + i, 1, "R5");
    // R7: head filled and released in the same cycle
    step(0, 1, 0, 32'hA0, 1, "R7");
    // R6: head held while not taken
    step(0, 0, 0, '0, 0, "R6");
    step(0, 0, 0, '0, 0, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 1, "R5");
    step(0, 0, 0, '0, 0, "R6");

    // R2/R3: fill to capacity across the wrap, then an ignored take
    for (int i = 0; i < CAP; i++) step(1, 0, 0, '0, 0, "R2");
    step(1, 0, 0, '0, 0, "R3");
    step(0, 0, 0, '0, 0, "R3");
    // R8: full at cycle start, so no issue while releasing; issue next cycle
    step(1, 1, q[0], 32'hBEEF, 1, "R8");
    step(1, 0, 0, '0, 0, "R8");
    // R4: fill every outstanding slot out of order (newest first)
    for (int k = q.size() - 1; k >= 0; k--) step(0, 1, q[k], 32'h100 + k, 0, "R4");
    // R8: steady issue and release in the same cycle
    for (int i = 0; i < 12; i++) step(1, 1, q[q.size() - 1], 32'h200 + i, 1, "R8");
    drain("R5");

    // R9: empty buffer, issue + put + release all in one cycle
    step(1, 1, ins, 32'h5A5A, 1, "R9");
    step(0, 0, 0, '0, 0, "R9");

    // Random traffic with out-of-order puts
    for (int c = 0; c < 4000; c++) begin
      int pick = -1;
      int cand[$];
      foreach (q[k]) if (!val[q[k]]) cand.push_back(q[k]);
      if (cand.size() > 0 && ($urandom % 3 != 0)) pick = cand[$urandom % cand.size()];
      step(($urandom % 4) != 0, pick >= 0, (pick >= 0) ? pick : 0, $urandom,
           ($urandom % 3) != 0, "R4");
    end
    drain("R5");
    step(0, 0, 0, '0, 0, "R6");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule